// File: doc/BRIEF.md
# Serial-Flash Controller Register and Interrupt Unit

This unit is the register front end of a serial-flash controller. It sits on a simple 32-bit register bus and decodes a fixed map of word registers. It holds the lane-width control word, the flash command word, the flash address, the DMA buffer address and a FIFO threshold. It drives these values to the flash sequencer, the FIFOs and the DMA engine. Writes to the data port become FIFO push strobes, and reads from it become pop strobes.

Eight event lines from the sequencer, the FIFOs and the DMA engine set sticky raw interrupt bits. A mask register hides individual bits, and a single interrupt line reports when any unmasked bit is pending. Software removes events by writing ones to a clear register.

Two registers act as one-shot triggers. The recovery register starts a soft reset that lasts a fixed number of cycles. During that reset the unit flushes the FIFOs, holds the sequencer idle and wipes the raw interrupts. The DMA trigger register issues a single start pulse. The lane-width control word cannot be changed while the sequencer reports busy.

Top module: `flash_csr_unit`

## Requirements
- R1: After the synchronous reset every held register reads zero, except the interrupt mask, which reads 0xFF. The irq, flush, DMA start, push and pop outputs are low.
- R2: Reads return data on bus_rdata one cycle after the access. The control word at byte offset 0x000 keeps only bits 13:12 (data lanes), 11:10 (address lanes), 9:8 (command lanes) and 1 (shift on falling edge); its other bits read zero. The command (0x100), flash address (0x104) and DMA address (0x084) registers read back all 32 bits. The threshold register (0x00C) reads back its low THR_W bits.
- R3: Bit 0 of the status register (0x024) shows seq_busy_i. A write to the control word while seq_busy_i is high leaves it unchanged.
- R4: A high event line sets its bit in the raw interrupt register (0x028). The bits are: bit 0 RX full, 1 RX underflow, 2 TX overflow, 3 TX empty, 4 transfer done, 5 bus error, 6 serial error, 7 DMA done. The mask register (0x004) holds one bit per event, and a 1 masks that event. The masked status (0x01C) reads raw AND NOT mask. irq is the OR of the masked bits, one cycle after the raw bits.
- R5: Writing ones to the clear register (0x008) clears the matching raw bits. An event in the same cycle as its clear leaves the bit set. The clear register reads zero.
- R6: Writing 1 to bit 0 of the recovery register (0x010) raises ctl_flush for exactly RST_CYCLES cycles, starting the cycle after the write. Bit 0 of that register reads 1 for the same cycles and then 0. While the reset runs the raw interrupts are held at zero, events are dropped, and new reset writes are ignored.
- R7: Writing a value with bit 0 set to the DMA trigger register (0x080) gives a one-cycle dma_start pulse in the next cycle. A value with bit 0 clear gives no pulse. The register always reads zero.
- R8: Offsets outside the map, including offsets that are not word aligned, read zero. Writes to them change no register and raise no strobe.
- R9: A write to the data port (0x108) gives a one-cycle fifo_tx_push in the next cycle, with fifo_tx_data holding the written word. A read from it gives a one-cycle fifo_rx_pop and returns fifo_rx_data as it was at the access.
- R10: The FIFO status register (0x020) reads: bit 0 TX full, 1 TX empty, 2 RX empty, 3 RX full, the TX level at bits 8 and up, and the RX level at bits 16 and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| seq_busy_i | input | 1 | Sequencer busy |
| evt_i | input | N_EVT | Event pulses, one per raw interrupt bit |
| fifo_tx_level | input | LVL_W | TX FIFO free level |
| fifo_rx_level | input | LVL_W | RX FIFO fill level |
| fifo_tx_full | input | 1 | TX FIFO full |
| fifo_tx_empty | input | 1 | TX FIFO empty |
| fifo_rx_full | input | 1 | RX FIFO full |
| fifo_rx_empty | input | 1 | RX FIFO empty |
| fifo_rx_data | input | 32 | Head word of the RX FIFO |
| fifo_tx_push | output | 1 | Push strobe |
| fifo_tx_data | output | 32 | Word to push |
| fifo_rx_pop | output | 1 | Pop strobe |
| ctl_flush | output | 1 | Soft reset active: flush the FIFOs and hold the sequencer idle |
| dma_start | output | 1 | DMA start pulse |
| dma_addr | output | 32 | DMA buffer address |
| cmd_word | output | 32 | Flash command word |
| flash_addr | output | 32 | Flash address word |
| fifo_thresh | output | THR_W | FIFO threshold |
| ctrl_data_lanes | output | 2 | Data lane width code |
| ctrl_addr_lanes | output | 2 | Address lane width code |
| ctrl_cmd_lanes | output | 2 | Command lane width code |
| ctrl_shift_neg | output | 1 | Shift data on the falling edge |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cases where an event and its clear arrive together. If a design let the clear win there, it would lose a completion event and a driver polling for it would hang. The bench also writes the control word while busy, which a careless design would accept, changing lane widths during a transfer. It counts the soft-reset window and posts events inside it: an off-by-one counter would release the FIFOs a cycle early or late, and a design without the hold would leave stale events pending after recovery. Writes to unaligned and unmapped offsets and DMA-trigger writes with bit 0 clear check for aliasing and for spurious strobes.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;

  // Byte offsets of the register map.
  localparam int unsigned OFS_CTRL     = 32'h000;
  localparam int unsigned OFS_IMASK    = 32'h004;
  localparam int unsigned OFS_ICLR     = 32'h008;
  localparam int unsigned OFS_THRESH   = 32'h00C;
  localparam int unsigned OFS_RECOVER  = 32'h010;
  localparam int unsigned OFS_ISTAT    = 32'h01C;
  localparam int unsigned OFS_FSTAT    = 32'h020;
  localparam int unsigned OFS_STAT     = 32'h024;
  localparam int unsigned OFS_IRAW     = 32'h028;
  localparam int unsigned OFS_DMA_GO   = 32'h080;
  localparam int unsigned OFS_DMA_ADDR = 32'h084;
  localparam int unsigned OFS_CMD      = 32'h100;
  localparam int unsigned OFS_FADDR    = 32'h104;
  localparam int unsigned OFS_DATA     = 32'h108;

  // Field positions that software decodes.
  localparam int unsigned CTRL_DLANE_LSB = 12;
  localparam int unsigned CTRL_ALANE_LSB = 10;
  localparam int unsigned CTRL_CLANE_LSB = 8;
  localparam int unsigned CTRL_NEG_BIT   = 1;

  localparam int unsigned FST_TX_FULL  = 0;
  localparam int unsigned FST_TX_EMPTY = 1;
  localparam int unsigned FST_RX_EMPTY = 2;
  localparam int unsigned FST_RX_FULL  = 3;
  localparam int unsigned FST_TXLV_LSB = 8;
  localparam int unsigned FST_RXLV_LSB = 16;

  typedef logic [1:0] lanes_t;

  typedef struct packed {
    lanes_t data_l;
    lanes_t addr_l;
    lanes_t cmd_l;
    logic   shift_neg;
  } ctrl_t;

  typedef struct packed {
    logic ctrl;
    logic imask;
    logic iclr;
    logic thresh;
    logic recover;
    logic istat;
    logic fstat;
    logic stat;
    logic iraw;
    logic dma_go;
    logic dma_addr;
    logic cmd;
    logic faddr;
    logic data;
  } hit_t;

endpackage

// File: rtl/flash_csr_decode.sv
module flash_csr_decode
  import flash_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);

  always_comb begin
    hit_o.ctrl     = (addr_i == ADDR_W'(OFS_CTRL));
    hit_o.imask    = (addr_i == ADDR_W'(OFS_IMASK));
    hit_o.iclr     = (addr_i == ADDR_W'(OFS_ICLR));
    hit_o.thresh   = (addr_i == ADDR_W'(OFS_THRESH));
    hit_o.recover  = (addr_i == ADDR_W'(OFS_RECOVER));
    hit_o.istat    = (addr_i == ADDR_W'(OFS_ISTAT));
    hit_o.fstat    = (addr_i == ADDR_W'(OFS_FSTAT));
    hit_o.stat     = (addr_i == ADDR_W'(OFS_STAT));
    hit_o.iraw     = (addr_i == ADDR_W'(OFS_IRAW));
    hit_o.dma_go   = (addr_i == ADDR_W'(OFS_DMA_GO));
    hit_o.dma_addr = (addr_i == ADDR_W'(OFS_DMA_ADDR));
    hit_o.cmd      = (addr_i == ADDR_W'(OFS_CMD));
    hit_o.faddr    = (addr_i == ADDR_W'(OFS_FADDR));
    hit_o.data     = (addr_i == ADDR_W'(OFS_DATA));
  end

endmodule

// File: rtl/flash_rst_timer.sv
module flash_rst_timer #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // A start request while the window is open is dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RST_CYCLES - 1);
    end
  end

  assign busy_o = busy_q;

  // Window length checker: counts consecutive busy cycles.
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_RST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_q == (CNT_W+1)'(RST_CYCLES))); // R6
  AST_RST_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q <= (CNT_W+1)'(RST_CYCLES)); // R6

endmodule

// File: rtl/flash_irq_block.sv
module flash_irq_block #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             mask_we_i,
  input  logic             clr_we_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] mask_o,
  output logic [N_EVT-1:0] raw_o,
  output logic [N_EVT-1:0] masked_o,
  output logic             irq_o
);

  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] raw_q;
  logic             irq_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    logic bit_q;
    logic clr_hit;
    assign clr_hit = clr_we_i & wdata_i[i];

    // Event has priority over a clear; the soft reset overrides both.
    always_ff @(posedge clk) begin
      if (rst || flush_i) bit_q <= 1'b0;
      else if (evt_i[i])  bit_q <= 1'b1;
      else if (clr_hit)   bit_q <= 1'b0;
    end
    assign raw_q[i] = bit_q;

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
      (!flush_i && evt_i[i]) |=> raw_q[i]); // R5
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (!flush_i && !evt_i[i] && clr_we_i && wdata_i[i]) |=> !raw_q[i]); // R5
  end

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '1;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_q & ~mask_q);
  end

  assign mask_o   = mask_q;
  assign raw_o    = raw_q;
  assign masked_o = raw_q & ~mask_q;
  assign irq_o    = irq_q;

  AST_RAW_WIPED: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (raw_q == '0)); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(flush_i) |=> !irq_q); // R4

endmodule

// File: rtl/flash_csr_unit.sv
module flash_csr_unit
  import flash_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned N_EVT      = 8,
  parameter int unsigned LVL_W      = 5,
  parameter int unsigned THR_W      = 5,
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_busy_i,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [LVL_W-1:0]  fifo_tx_level,
  input  logic [LVL_W-1:0]  fifo_rx_level,
  input  logic              fifo_tx_full,
  input  logic              fifo_tx_empty,
  input  logic              fifo_rx_full,
  input  logic              fifo_rx_empty,
  input  logic [31:0]       fifo_rx_data,
  output logic              fifo_tx_push,
  output logic [31:0]       fifo_tx_data,
  output logic              fifo_rx_pop,
  output logic              ctl_flush,
  output logic              dma_start,
  output logic [31:0]       dma_addr,
  output logic [31:0]       cmd_word,
  output logic [31:0]       flash_addr,
  output logic [THR_W-1:0]  fifo_thresh,
  output logic [1:0]        ctrl_data_lanes,
  output logic [1:0]        ctrl_addr_lanes,
  output logic [1:0]        ctrl_cmd_lanes,
  output logic              ctrl_shift_neg,
  output logic              irq
);

  hit_t hit;
  logic wr_acc, rd_acc;
  assign wr_acc = bus_sel &  bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  flash_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .hit_o  (hit)
  );

  // Soft reset window
  logic rst_busy;
  flash_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk     (clk),
    .rst     (rst),
    .start_i (wr_acc & hit.recover & bus_wdata[0]),
    .busy_o  (rst_busy)
  );
  assign ctl_flush = rst_busy;

  // Interrupt logic
  logic [N_EVT-1:0] mask_v, raw_v, masked_v;
  flash_irq_block #(.N_EVT(N_EVT)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .flush_i   (rst_busy),
    .evt_i     (evt_i),
    .mask_we_i (wr_acc & hit.imask),
    .clr_we_i  (wr_acc & hit.iclr),
    .wdata_i   (bus_wdata[N_EVT-1:0]),
    .mask_o    (mask_v),
    .raw_o     (raw_v),
    .masked_o  (masked_v),
    .irq_o     (irq)
  );

  // Held registers
  ctrl_t             ctrl_q;
  logic [31:0]       cmd_q, faddr_q, daddr_q, txd_q, rdata_q;
  logic [THR_W-1:0]  thr_q;
  logic              dma_go_q, push_q, pop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      faddr_q <= '0;
      daddr_q <= '0;
      thr_q   <= '0;
    end else if (wr_acc) begin
      if (hit.ctrl && !seq_busy_i) begin
        ctrl_q.data_l    <= bus_wdata[CTRL_DLANE_LSB +: 2];
        ctrl_q.addr_l    <= bus_wdata[CTRL_ALANE_LSB +: 2];
        ctrl_q.cmd_l     <= bus_wdata[CTRL_CLANE_LSB +: 2];
        ctrl_q.shift_neg <= bus_wdata[CTRL_NEG_BIT];
      end
      if (hit.cmd)      cmd_q   <= bus_wdata;
      if (hit.faddr)    faddr_q <= bus_wdata;
      if (hit.dma_addr) daddr_q <= bus_wdata;
      if (hit.thresh)   thr_q   <= bus_wdata[THR_W-1:0];
    end
  end

  // One-shot strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_go_q <= 1'b0;
      push_q   <= 1'b0;
      pop_q    <= 1'b0;
      txd_q    <= '0;
    end else begin
      dma_go_q <= wr_acc & hit.dma_go & bus_wdata[0];
      push_q   <= wr_acc & hit.data;
      pop_q    <= rd_acc & hit.data;
      if (wr_acc && hit.data) txd_q <= bus_wdata;
    end
  end

  // Read mux
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit.ctrl) begin
      rd_val[CTRL_DLANE_LSB +: 2] = ctrl_q.data_l;
      rd_val[CTRL_ALANE_LSB +: 2] = ctrl_q.addr_l;
      rd_val[CTRL_CLANE_LSB +: 2] = ctrl_q.cmd_l;
      rd_val[CTRL_NEG_BIT]        = ctrl_q.shift_neg;
    end
    if (hit.imask)    rd_val[N_EVT-1:0] = mask_v;
    if (hit.thresh)   rd_val[THR_W-1:0] = thr_q;
    if (hit.recover)  rd_val[0]         = rst_busy;
    if (hit.istat)    rd_val[N_EVT-1:0] = masked_v;
    if (hit.fstat) begin
      rd_val[FST_TX_FULL]              = fifo_tx_full;
      rd_val[FST_TX_EMPTY]             = fifo_tx_empty;
      rd_val[FST_RX_EMPTY]             = fifo_rx_empty;
      rd_val[FST_RX_FULL]              = fifo_rx_full;
      rd_val[FST_TXLV_LSB +: LVL_W]    = fifo_tx_level;
      rd_val[FST_RXLV_LSB +: LVL_W]    = fifo_rx_level;
    end
    if (hit.stat)     rd_val[0]         = seq_busy_i;
    if (hit.iraw)     rd_val[N_EVT-1:0] = raw_v;
    if (hit.dma_addr) rd_val            = daddr_q;
    if (hit.cmd)      rd_val            = cmd_q;
    if (hit.faddr)    rd_val            = faddr_q;
    if (hit.data)     rd_val            = fifo_rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_val;
  end

  assign bus_rdata       = rdata_q;
  assign fifo_tx_push    = push_q;
  assign fifo_tx_data    = txd_q;
  assign fifo_rx_pop     = pop_q;
  assign dma_start       = dma_go_q;
  assign dma_addr        = daddr_q;
  assign cmd_word        = cmd_q;
  assign flash_addr      = faddr_q;
  assign fifo_thresh     = thr_q;
  assign ctrl_data_lanes = ctrl_q.data_l;
  assign ctrl_addr_lanes = ctrl_q.addr_l;
  assign ctrl_cmd_lanes  = ctrl_q.cmd_l;
  assign ctrl_shift_neg  = ctrl_q.shift_neg;

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && hit.ctrl && seq_busy_i) |=> $stable({ctrl_data_lanes, ctrl_addr_lanes,
                                                    ctrl_cmd_lanes, ctrl_shift_neg})); // R3
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> $past(wr_acc && hit.dma_go && bus_wdata[0])); // R7
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fifo_tx_push |-> $past(wr_acc && hit.data)); // R9
  AST_POP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fifo_rx_pop |-> $past(rd_acc && hit.data)); // R9
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R8
  AST_RSVD_NOEFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && hit == '0) |=> ($stable(cmd_word) && $stable(flash_addr) &&
                               $stable(dma_addr) && !dma_start && !fifo_tx_push)); // R8

endmodule

// File: tb/flash_csr_unit_tb.sv
module flash_csr_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy_in = 1'b0;
  logic [7:0]  evt = '0;
  logic [4:0]  tx_lv = '0, rx_lv = '0;
  logic        txf = 1'b0, txe = 1'b0, rxf = 1'b0, rxe = 1'b0;
  logic [31:0] rxd = '0;
  logic        push, pop, flush, dgo, irq, neg;
  logic [31:0] txd, daddr, cmd, faddr;
  logic [4:0]  thr;
  logic [1:0]  dl, al, cl;

  always #2.5 clk = ~clk;

  flash_csr_unit u_dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .seq_busy_i(busy_in), .evt_i(evt),
    .fifo_tx_level(tx_lv), .fifo_rx_level(rx_lv), .fifo_tx_full(txf),
    .fifo_tx_empty(txe), .fifo_rx_full(rxf), .fifo_rx_empty(rxe),
    .fifo_rx_data(rxd), .fifo_tx_push(push), .fifo_tx_data(txd),
    .fifo_rx_pop(pop), .ctl_flush(flush), .dma_start(dgo), .dma_addr(daddr),
    .cmd_word(cmd), .flash_addr(faddr), .fifo_thresh(thr),
    .ctrl_data_lanes(dl), .ctrl_addr_lanes(al), .ctrl_cmd_lanes(cl),
    .ctrl_shift_neg(neg), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]  m_dl, m_al, m_cl;
  logic        m_neg, m_irq, m_dma, m_push, m_pop;
  logic [31:0] m_cmd, m_fa, m_da, m_txd, m_rdata;
  logic [4:0]  m_thr;
  logic [7:0]  m_mask, m_raw;
  int          m_left;

  function automatic logic [31:0] model_read(input logic [8:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      9'h000: begin r[13:12] = m_dl; r[11:10] = m_al; r[9:8] = m_cl; r[1] = m_neg; end
      9'h004: r[7:0] = m_mask;
      9'h00C: r[4:0] = m_thr;
      9'h010: r[0] = (m_left > 0);
      9'h01C: r[7:0] = m_raw & ~m_mask;
      9'h020: begin r[0] = txf; r[1] = txe; r[2] = rxe; r[3] = rxf;
                    r[12:8] = tx_lv; r[20:16] = rx_lv; end
      9'h024: r[0] = busy_in;
      9'h028: r[7:0] = m_raw;
      9'h084: r = m_da;
      9'h100: r = m_cmd;
      9'h104: r = m_fa;
      9'h108: r = rxd;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dl = 0; m_al = 0; m_cl = 0; m_neg = 0; m_irq = 0; m_dma = 0;
      m_push = 0; m_pop = 0; m_cmd = 0; m_fa = 0; m_da = 0; m_txd = 0;
      m_rdata = 0; m_thr = 0; m_mask = 8'hFF; m_raw = 0; m_left = 0;
    end else begin
      logic        w, r, busy_now;
      logic [7:0]  clr;
      w = sel & wr;
      r = sel & ~wr;
      busy_now = (m_left > 0);
      if (r) m_rdata = model_read(addr);
      m_irq = |(m_raw & ~m_mask);
      clr = (w && addr == 9'h008) ? wdata[7:0] : 8'h00;
      m_raw = busy_now ? 8'h00 : ((m_raw & ~clr) | evt);
      if (w && addr == 9'h004) m_mask = wdata[7:0];
      if (w && addr == 9'h000 && !busy_in) begin
        m_dl = wdata[13:12]; m_al = wdata[11:10]; m_cl = wdata[9:8]; m_neg = wdata[1];
      end
      if (w && addr == 9'h100) m_cmd = wdata;
      if (w && addr == 9'h104) m_fa = wdata;
      if (w && addr == 9'h084) m_da = wdata;
      if (w && addr == 9'h00C) m_thr = wdata[4:0];
      if (busy_now) m_left = m_left - 1;
      else if (w && addr == 9'h010 && wdata[0]) m_left = 8;
      m_dma  = w && addr == 9'h080 && wdata[0];
      m_push = w && addr == 9'h108;
      if (m_push) m_txd = wdata;
      m_pop  = r && addr == 9'h108;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(irq === m_irq, "R4 irq", {31'b0, irq}, {31'b0, m_irq});
      chk(dgo === m_dma, "R7 dma_start", {31'b0, dgo}, {31'b0, m_dma});
      chk(flush === (m_left > 0), "R6 ctl_flush", {31'b0, flush}, {31'b0, (m_left > 0)});
      chk({dl, al, cl, neg} === {m_dl, m_al, m_cl, m_neg}, "R3 ctrl fields",
          {25'b0, dl, al, cl, neg}, {25'b0, m_dl, m_al, m_cl, m_neg});
      chk(cmd === m_cmd, "R2 cmd_word", cmd, m_cmd);
      chk(faddr === m_fa, "R2 flash_addr", faddr, m_fa);
      chk(daddr === m_da, "R2 dma_addr", daddr, m_da);
      chk(thr === m_thr, "R2 fifo_thresh", {27'b0, thr}, {27'b0, m_thr});
      chk(push === m_push, "R9 push", {31'b0, push}, {31'b0, m_push});
      chk(txd === m_txd, "R9 tx_data", txd, m_txd);
      chk(pop === m_pop, "R9 pop", {31'b0, pop}, {31'b0, m_pop});
      chk(rdata === m_rdata, "R2 rdata", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers (entered at a falling edge) ----------------
  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic rd_expect(input logic [8:0] a, input logic [31:0] exp, input string tag);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [8:0] offs [16] = '{9'h000, 9'h004, 9'h008, 9'h00C, 9'h010, 9'h01C, 9'h020, 9'h024,
                            9'h028, 9'h080, 9'h084, 9'h100, 9'h104, 9'h108, 9'h014, 9'h10C};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    // R1: reset state
    chk(irq === 1'b0 && flush === 1'b0 && dgo === 1'b0, "R1 strobes low", {29'b0, irq, flush, dgo}, 0);
    chk(cmd === 0 && {dl, al, cl, neg} === 0, "R1 held regs zero", cmd, 0);
    rd_expect(9'h004, 32'h0000_00FF, "R1 mask reset");
    rd_expect(9'h000, 32'h0, "R1 ctrl reset");

    // R2: control word field packing
    bus_write(9'h000, 32'hFFFF_FFFF);
    rd_expect(9'h000, 32'h0000_3F02, "R2 ctrl fields only");
    bus_write(9'h000, 32'h0000_2400);
    rd_expect(9'h000, 32'h0000_2400, "R2 ctrl readback");

    // R3: frozen while busy
    busy_in = 1;
    bus_write(9'h000, 32'h0000_3F02);
    rd_expect(9'h024, 32'h1, "R3 busy visible");
    rd_expect(9'h000, 32'h0000_2400, "R3 ctrl frozen");
    busy_in = 0;

    bus_write(9'h100, 32'hA5C3_0F0B);
    bus_write(9'h104, 32'h0012_3456);
    bus_write(9'h084, 32'h8000_1000);
    bus_write(9'h00C, 32'hFFFF_FFEA);
    rd_expect(9'h100, 32'hA5C3_0F0B, "R2 cmd readback");
    rd_expect(9'h00C, 32'h0000_000A, "R2 threshold width");

    // R4 / R5: events, mask, clear
    bus_write(9'h004, 32'h0);
    evt = 8'h05; @(negedge clk); evt = 0;
    rd_expect(9'h028, 32'h05, "R4 raw set");
    chk(irq === 1'b1, "R4 irq raised", {31'b0, irq}, 1);
    bus_write(9'h004, 32'h04);
    rd_expect(9'h01C, 32'h01, "R4 masked status");
    bus_write(9'h008, 32'h01);
    rd_expect(9'h028, 32'h04, "R5 clear one bit");
    idle(1);
    chk(irq === 1'b0, "R4 irq all masked", {31'b0, irq}, 0);
    evt = 8'h04; bus_write(9'h008, 32'h04); evt = 0;
    rd_expect(9'h028, 32'h04, "R5 event beats clear");
    rd_expect(9'h008, 32'h0, "R5 clear reads zero");
    bus_write(9'h008, 32'hFFFF_FFFF);
    rd_expect(9'h028, 32'h0, "R5 clear all");

    // R6: soft reset window
    evt = 8'h81; @(negedge clk); evt = 0;
    bus_write(9'h010, 32'h1);
    begin
      int ones = 0;
      for (int k = 0; k < 12; k++) begin
        if (flush) ones++;
        if (k == 2) evt = 8'h10;
        if (k == 3) begin evt = 0; sel = 1; wr = 1; addr = 9'h010; wdata = 1; end
        if (k == 4) begin sel = 0; wr = 0; end
        @(negedge clk);
      end
      chk(ones == 8, "R6 window length", ones, 8);
    end
    rd_expect(9'h010, 32'h0, "R6 recover done");
    rd_expect(9'h028, 32'h0, "R6 raw wiped");
    bus_write(9'h010, 32'h1);
    rd_expect(9'h010, 32'h1, "R6 recover reads busy");
    idle(10);

    // R7: DMA trigger
    sel = 1; wr = 1; addr = 9'h080; wdata = 32'h1;
    @(negedge clk); sel = 0; wr = 0;
    chk(dgo === 1'b1, "R7 pulse", {31'b0, dgo}, 1);
    @(negedge clk);
    chk(dgo === 1'b0, "R7 self clear", {31'b0, dgo}, 0);
    bus_write(9'h080, 32'hFFFF_FFFE);
    rd_expect(9'h080, 32'h0, "R7 reads zero");

    // R8: reserved offsets
    bus_write(9'h014, 32'hFFFF_FFFF);
    bus_write(9'h040, 32'hFFFF_FFFF);
    bus_write(9'h10C, 32'hFFFF_FFFF);
    bus_write(9'h101, 32'hFFFF_FFFF);
    rd_expect(9'h014, 32'h0, "R8 reserved reads zero");
    rd_expect(9'h101, 32'h0, "R8 unaligned reads zero");
    rd_expect(9'h100, 32'hA5C3_0F0B, "R8 no alias write");

    // R9: data port
    sel = 1; wr = 1; addr = 9'h108; wdata = 32'hCAFE_0001;
    @(negedge clk); sel = 0; wr = 0;
    chk(push === 1'b1 && txd === 32'hCAFE_0001, "R9 push data", txd, 32'hCAFE_0001);
    rxd = 32'h1234_5678;
    rd_expect(9'h108, 32'h1234_5678, "R9 pop data");

    // R10: FIFO status layout
    tx_lv = 5'd3; rx_lv = 5'd17; txf = 0; txe = 1; rxe = 0; rxf = 1;
    rd_expect(9'h020, 32'h0011_030A, "R10 fifo status");

    // Mixed random traffic against the model
    for (int n = 0; n < 800; n++) begin
      sel = ($urandom % 10) < 7;
      wr = $urandom % 2;
      addr = offs[$urandom % 16];
      wdata = $urandom;
      evt = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      busy_in = ($urandom % 3) == 0;
      rxd = $urandom;
      tx_lv = 5'($urandom); rx_lv = 5'($urandom);
      {txf, txe, rxe, rxf} = 4'($urandom);
      @(negedge clk);
    end
    sel = 0; wr = 0; evt = 0; busy_in = 0;
    idle(12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule